// File: doc/BRIEF.md
# Word Reservation Monitor for Load-Reserve / Store-Conditional

This block holds the single memory reservation of one hart and uses it to carry out word-sized load-reserve and store-conditional operations. Both operations form their effective address as the index operand plus either the base operand or zero. A load-reserve reads the 32-bit word at that address. It returns the word zero-extended to the full register width and records a reservation with its address and a 4-byte length.

A store-conditional checks the request against the reservation it holds. It writes the low word of the store data when the reservation matches, or in a configurable same-page mismatch case. It returns a 4-bit condition code and always drops the reservation.

Requests arrive through a valid/ready handshake, and only one operation is in flight at a time. The block drives a simple read/write memory port. It raises a one-cycle result strobe one cycle after the memory responds. A store-conditional that does not write skips the memory port entirely. Addresses are real addresses; no translation is applied.

Top module: `lrsc_monitor`

## Requirements
- R1: The effective address is `req_index` plus `req_base`. When `req_base_zero` is 1, `req_base` is replaced by zero.
- R2: An accepted load-reserve (`req_op`=0) marks the reservation valid with a length of 4 bytes and the effective address. A later load-reserve replaces any earlier reservation.
- R3: A load-reserve reads the word at the effective address and never writes memory. Its result is that word in `res_data[31:0]`, with `res_data[63:32]` zero and `res_cr` 0.
- R4: A store-conditional (`req_op`=1) writes `req_sdata[31:0]` to the effective address when the reservation is valid, its length is 4 and its address equals the effective address. In that case `res_cr[1]` is 1.
- R5: When no reservation is valid, a store-conditional makes no memory access and reports `res_cr[1]`=0. Its result appears on the first cycle after acceptance.
- R6: When a reservation is valid but lies in a different page (address bits above log2(PAGE_BYTES)), a store-conditional makes no memory access and reports `res_cr[1]`=0.
- R7: For a store-conditional, `res_cr` is {2'b00, store-success bit, `req_so`}. In this code bit 3 is the most significant bit and bit 0 copies the summary-overflow input.
- R8: With SAME_PAGE_STORE=1 (the default), a valid reservation in the same page but at a different address causes the word to be written, while `res_cr[1]` reports 0.
- R9: Every accepted store-conditional clears the reservation, whatever its outcome.
- R10: `req_ready` is high only when no operation is in flight. For an operation that uses memory, `res_valid` rises one cycle after `mem_rsp_valid` and lasts exactly one cycle.
- R11: A synchronous reset clears the reservation flag, address and length, and leaves the block idle with `req_ready`=1, `mem_req_valid`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_op | input | 1 | 0 load-reserve, 1 store-conditional |
| req_base | input | XLEN | Base operand |
| req_index | input | XLEN | Index operand |
| req_base_zero | input | 1 | Use zero instead of the base operand |
| req_sdata | input | XLEN | Store data; low word is written |
| req_so | input | 1 | Summary-overflow bit copied into the condition code |
| mem_req_valid | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | XLEN | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory has completed the access |
| mem_rdata | input | 32 | Read data, valid with the response |
| res_valid | output | 1 | Result strobe |
| res_data | output | XLEN | Load result, zero for store-conditional |
| res_cr | output | 4 | Condition code |

## Verification
The bench uses the defaults: XLEN of 64, a 4096-byte page and the same-page store choice enabled. These values let a handful of hand-picked addresses cover every branch of the comparison. An exact match, an offset inside one page, a jump to a distant page and a step across the 0x1FFC/0x2000 page edge all appear in the stimulus. Each vector also fixes the expected latency. This separates store-conditionals that go to memory from those that must skip it.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int XLEN            = 64,
  parameter int PAGE_BYTES      = 4096,
  parameter bit SAME_PAGE_STORE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_op,
  input  logic [XLEN-1:0] req_base,
  input  logic [XLEN-1:0] req_index,
  input  logic            req_base_zero,
  input  logic [XLEN-1:0] req_sdata,
  input  logic            req_so,
  output logic            mem_req_valid,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rdata,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic [3:0]      res_cr
);
  localparam int PG = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DONE} st_t;
  st_t st;

  logic            rsv_vld;
  logic [3:0]      rsv_len;
  logic [XLEN-1:0] rsv_addr;
  logic            op_q, we_q;
  logic [XLEN-1:0] ea_q;
  logic [31:0]     wd_q, rd_q;
  logic [3:0]      cr_q;

  wire [XLEN-1:0] ea = (req_base_zero ? '0 : req_base) + req_index;
  wire accept     = req_valid && req_ready;
  wire exact_hit  = rsv_vld && rsv_len == 4'd4 && rsv_addr == ea;
  wire page_hit   = rsv_vld && rsv_addr[XLEN-1:PG] == ea[XLEN-1:PG];
  wire sc_write   = exact_hit || (page_hit && SAME_PAGE_STORE);
  wire unused_hi  = ^req_sdata[XLEN-1:32];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      rsv_vld  <= 1'b0;
      rsv_len  <= '0;
      rsv_addr <= '0;
      op_q     <= 1'b0;
      we_q     <= 1'b0;
      ea_q     <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
      cr_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          ea_q <= ea;
          op_q <= req_op;
          wd_q <= req_sdata[31:0];
          if (!req_op) begin
            rsv_vld  <= 1'b1;
            rsv_len  <= 4'd4;
            rsv_addr <= ea;
            we_q     <= 1'b0;
            cr_q     <= '0;
            st       <= S_MEM;
          end else begin
            rsv_vld <= 1'b0;
            we_q    <= sc_write;
            cr_q    <= {2'b00, exact_hit, req_so};
            st      <= sc_write ? S_MEM : S_DONE;
          end
        end
        S_MEM: if (mem_rsp_valid) begin
          if (!op_q) rd_q <= mem_rdata;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = st == S_IDLE;
  assign mem_req_valid = st == S_MEM;
  assign mem_we        = we_q;
  assign mem_addr      = ea_q;
  assign mem_wdata     = wd_q;
  assign res_valid     = st == S_DONE;
  assign res_data      = op_q ? '0 : {{(XLEN-32){1'b0}}, rd_q};
  assign res_cr        = cr_q;
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_op,
  input logic [XLEN-1:0] req_base,
  input logic [XLEN-1:0] req_index,
  input logic            req_base_zero,
  input logic            mem_req_valid,
  input logic            mem_we,
  input logic            res_valid,
  input logic [XLEN-1:0] res_data,
  input logic [3:0]      res_cr,
  input logic            rsv_vld,
  input logic [3:0]      rsv_len,
  input logic [XLEN-1:0] rsv_addr,
  input logic            op_q
);
  AST_LR_RECORDS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_op) |=> (rsv_vld && rsv_len == 4'd4 &&
      rsv_addr == $past((req_base_zero ? '0 : req_base) + req_index))); // R2
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op) |=> !rsv_vld); // R9
  AST_LR_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !op_q) |-> (res_data[XLEN-1:32] == '0 && res_cr == 4'd0)); // R3
  AST_LR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !op_q) |-> !mem_we); // R3
  AST_CR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_cr[3:2] == 2'b00); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req_valid && !res_valid)); // R10
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rsv_vld && rsv_len == 4'd0 && rsv_addr == '0 && req_ready)); // R11
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_base(req_base), .req_index(req_index),
  .req_base_zero(req_base_zero), .mem_req_valid(mem_req_valid),
  .mem_we(mem_we), .res_valid(res_valid), .res_data(res_data),
  .res_cr(res_cr), .rsv_vld(rsv_vld), .rsv_len(rsv_len),
  .rsv_addr(rsv_addr), .op_q(op_q)
);

// File: tb/lrsc_monitor_bench.sv
module lrsc_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_op = 1'b0, req_base_zero = 1'b0, req_so = 1'b0;
  logic [63:0] req_base = '0, req_index = '0, req_sdata = '0;
  logic        req_ready, mem_req_valid, mem_we, res_valid;
  logic [63:0] mem_addr, res_data;
  logic [31:0] mem_wdata;
  logic [3:0]  res_cr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] mem [logic [63:0]];

  always #5 clk = ~clk;

  lrsc_monitor u_lrsc_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_index(req_index),
    .req_base_zero(req_base_zero), .req_sdata(req_sdata), .req_so(req_so),
    .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_data(res_data), .res_cr(res_cr)
  );

  function automatic logic [31:0] peek(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && !mem_rsp_valid) begin
      mem_rsp_valid <= 1'b1;
      mem_rdata     <= peek(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  typedef struct packed {
    logic        op;
    logic [63:0] base;
    logic [63:0] index;
    logic        bz;
    logic [63:0] sdata;
    logic        so;
    logic [63:0] exp_data;
    logic [3:0]  exp_cr;
    logic [31:0] exp_mem;
    logic [3:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 64'h1000, 64'h0,    1'b0, 64'h0,                  1'b0, 64'hCAFEF00D, 4'b0000, 32'hCAFEF00D, 4'd3, 4'd3},  // R3
    '{1'b1, 64'h1000, 64'h0,    1'b0, 64'hFFFFFFFF_AAAA0001,  1'b1, 64'h0,        4'b0011, 32'hAAAA0001, 4'd3, 4'd4},  // R4
    '{1'b1, 64'h1000, 64'h0,    1'b0, 64'h2,                  1'b0, 64'h0,        4'b0000, 32'hAAAA0001, 4'd1, 4'd5},  // R5
    '{1'b0, 64'hDEAD, 64'h1010, 1'b1, 64'h0,                  1'b0, 64'h11112222, 4'b0000, 32'h11112222, 4'd3, 4'd1},  // R1
    '{1'b1, 64'h1000, 64'h14,   1'b0, 64'h77778888,           1'b1, 64'h0,        4'b0001, 32'h77778888, 4'd3, 4'd8},  // R8
    '{1'b0, 64'h3000, 64'h0,    1'b0, 64'h0,                  1'b0, 64'h55556666, 4'b0000, 32'h55556666, 4'd3, 4'd2},  // R2
    '{1'b1, 64'h1000, 64'h0,    1'b0, 64'h44,                 1'b1, 64'h0,        4'b0001, 32'hAAAA0001, 4'd1, 4'd6},  // R6
    '{1'b0, 64'h2FF0, 64'h10,   1'b0, 64'h0,                  1'b0, 64'h55556666, 4'b0000, 32'h55556666, 4'd3, 4'd1},  // R1
    '{1'b1, 64'h3000, 64'h0,    1'b0, 64'h9999AAAA,           1'b0, 64'h0,        4'b0010, 32'h9999AAAA, 4'd3, 4'd4},  // R4
    '{1'b0, 64'h1FFC, 64'h0,    1'b0, 64'h0,                  1'b0, 64'h0BADBEEF, 4'b0000, 32'h0BADBEEF, 4'd3, 4'd3},  // R3
    '{1'b1, 64'h2000, 64'h0,    1'b0, 64'h12345678,           1'b0, 64'h0,        4'b0000, 32'h0,        4'd1, 4'd6},  // R6
    '{1'b0, 64'h1010, 64'h0,    1'b0, 64'h0,                  1'b0, 64'h11112222, 4'b0000, 32'h11112222, 4'd3, 4'd2},  // R2
    '{1'b0, 64'h1000, 64'h0,    1'b0, 64'h0,                  1'b0, 64'hAAAA0001, 4'b0000, 32'hAAAA0001, 4'd3, 4'd2},  // R2
    '{1'b1, 64'h1010, 64'h0,    1'b0, 64'h5A5A5A5A,           1'b0, 64'h0,        4'b0000, 32'h5A5A5A5A, 4'd3, 4'd8},  // R8
    '{1'b1, 64'h1000, 64'h0,    1'b0, 64'h3,                  1'b0, 64'h0,        4'b0000, 32'hAAAA0001, 4'd1, 4'd9}   // R9
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(vec_t v, string tag);
    int lat = 0;
    @(negedge clk);
    check({tag, " R10 ready"}, {63'b0, req_ready}, 64'd1);
    req_op = v.op; req_base = v.base; req_index = v.index;
    req_base_zero = v.bz; req_sdata = v.sdata; req_so = v.so; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check({tag, " R10 latency"}, 64'(lat), 64'(v.lat));
    check({tag, " data"}, res_data, v.exp_data);
    check({tag, " R7 cr"}, {60'b0, res_cr}, {60'b0, v.exp_cr});
    check({tag, " memory"}, {32'b0, peek((v.bz ? 64'h0 : v.base) + v.index)}, {32'b0, v.exp_mem});
    @(negedge clk);
    check({tag, " R10 pulse"}, {63'b0, res_valid}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mem[64'h1000] = 32'hCAFEF00D;
    mem[64'h1010] = 32'h11112222;
    mem[64'h3000] = 32'h55556666;
    mem[64'h1FFC] = 32'h0BADBEEF;
    repeat (3) @(negedge clk);
    check("R11 ready", {63'b0, req_ready}, 64'd1);
    check("R11 mem idle", {63'b0, mem_req_valid}, 64'd0);
    check("R11 res idle", {63'b0, res_valid}, 64'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d R%0d", i, VEC[i].req));
    // R11: a reservation does not survive reset
    run('{1'b0, 64'h3000, 64'h0, 1'b0, 64'h0, 1'b0, 64'h9999AAAA, 4'b0000, 32'h9999AAAA, 4'd3, 4'd11}, "R11 lr");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    run('{1'b1, 64'h3000, 64'h0, 1'b0, 64'h1, 1'b1, 64'h0, 4'b0001, 32'h9999AAAA, 4'd1, 4'd11}, "R11 sc");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule